// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator

This block turns a virtual address into a physical address for a single-level linear page table. A requester hands it a virtual address with an access kind (read, write or execute). The block first searches a small fully associative translation cache. On a hit it answers straight from the cache and does not touch memory. On a miss a hardware walker works out where the page table entry lives: the page table base input plus the page number times the entry size. It fetches that entry over a simple request/response memory port, checks the entry's valid, present and permission bits, loads a clean translation into the cache and reports the result.

The result comes as a one-cycle completion pulse. It carries either the physical address or a fault code. A missing or non-present page gives a segmentation fault. An access the entry's permissions forbid gives a protection fault. A flush input empties the cache in one cycle, so the requester can drop stale translations after it changes the table.

Top module: `mmu_translate_top`

## Requirements
- R1: The low OFF_W bits of the virtual address form the page offset and the bits above them form the page number. With 16-byte pages, address 21 (0b010101) is page 1, offset 5.
- R2: On a miss, `memReq` is high for exactly one cycle and `memAddr` = `ptBase` + page number × PTE_BYTES.
- R3: The physical address is the entry's frame number (bits PTE_W-1 down to PTE_W-PFN_W) shifted left by OFF_W, ORed with the offset.
- R4: An entry with bit 0 (valid) or bit 1 (present) clear completes with `fault` = 1 (segmentation) and `pa` = 0, and it is not cached: repeating the request reads memory again.
- R5: Entry bits 2, 3 and 4 grant read, write and execute. `reqAcc` 0 is a read, 1 a write, and 2 or 3 an execute. A forbidden access completes with `fault` = 2 (protection) and `pa` = 0, and a walk that faults this way is not cached.
- R6: The valid/present check comes before the permission check. An invalid entry with no permissions reports fault 1.
- R7: A cache hit raises `done` on the second falling edge after the request is presented and makes no memory request.
- R8: A miss walks the table, tolerates any number of response wait cycles (`done` comes 4 + wait cycles after the request), and caches a clean translation so the next access to that page hits.
- R9: A cache hit applies the same permission check, and a forbidden hit reports fault 2 with no memory access.
- R10: The cache holds 4 translations and fills them in round-robin order. With the cache full, the next fill replaces the oldest filled slot.
- R11: A one-cycle `flush` invalidates every cached translation. A flush in the same cycle as a fill wins, so the filled page is not cached.
- R12: `done` lasts exactly one cycle. `reqReady` is low from acceptance until completion, and requests presented while it is low are ignored.
- R13: After reset the cache is empty, `done` and `memReq` are low, `reqReady` is high, and `fault` and `pa` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle, request will be accepted |
| reqVa | input | VA_W | Virtual address |
| reqAcc | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| ptBase | input | MADDR_W | Page table base address, held stable during translation |
| flush | input | 1 | Invalidate all cached translations |
| memReq | output | 1 | Page table entry read request (one cycle) |
| memAddr | output | MADDR_W | Page table entry address |
| memRespValid | input | 1 | Read data valid |
| memRdata | input | PTE_W | Page table entry read data |
| done | output | 1 | Translation complete (one cycle) |
| fault | output | 2 | 0 none, 1 segmentation, 2 protection |
| pa | output | PFN_W+OFF_W | Physical address, 0 on a fault |

## Verification
The bench widens the virtual address to 8 bits with 4 offset bits. That gives 16 pages against a 4-slot cache, so round-robin eviction and refills can be observed, while address 21 still splits into page 1, offset 5. Frames are 4 bits, entries 16 bits wide and 2 bytes apart, and the table sits at base 0x100 in a 12-bit memory space. The memory model's response delay varies from request to request. Because the bench counts memory requests, it can tell hits, misses and uncached faults apart from the ports alone.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef struct packed {
    logic latchReq;
    logic finishHit;
    logic finishWalk;
  } ctl_strb_t;

  // rwx: bit0 read, bit1 write, bit2 execute
  function automatic logic accessOk(input logic [1:0] acc, input logic [2:0] rwx);
    case (acc)
      2'd0:    accessOk = rwx[0];
      2'd1:    accessOk = rwx[1];
      default: accessOk = rwx[2];
    endcase
  endfunction

endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int N     = 4,
  parameter int VPN_W = 2,
  parameter int PFN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VPN_W-1:0] lookVpn,
  output logic             hit,
  output logic [PFN_W-1:0] hitPfn,
  output logic [2:0]       hitRwx,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic [2:0]       fillRwx
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vldQ;
  logic [VPN_W-1:0] vpnQ [N];
  logic [PFN_W-1:0] pfnQ [N];
  logic [2:0]       rwxQ [N];
  logic [PTR_W-1:0] ptrQ;
  logic [N-1:0]     hitVec;

  for (genvar g = 0; g < N; g++) begin : gCmp
    assign hitVec[g] = vldQ[g] && (vpnQ[g] == lookVpn);
  end

  always_comb begin
    hit    = |hitVec;
    hitPfn = '0;
    hitRwx = '0;
    for (int i = 0; i < N; i++) begin
      if (hitVec[i]) begin
        hitPfn = hitPfn | pfnQ[i];
        hitRwx = hitRwx | rwxQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ <= '0;
      ptrQ <= '0;
      for (int i = 0; i < N; i++) begin
        vpnQ[i] <= '0;
        pfnQ[i] <= '0;
        rwxQ[i] <= '0;
      end
    end else if (flush) begin
      vldQ <= '0;
    end else if (fillEn) begin
      for (int i = 0; i < N; i++) begin
        if (ptrQ == PTR_W'(i)) begin
          vldQ[i] <= 1'b1;
          vpnQ[i] <= fillVpn;
          pfnQ[i] <= fillPfn;
          rwxQ[i] <= fillRwx;
        end
      end
      ptrQ <= (ptrQ == PTR_W'(N - 1)) ? '0 : ptrQ + 1'b1;
    end
  end

  a_r10_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (vldQ == '0));

endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      tlbHit,
  input  logic      memRespValid,
  output logic      reqReady,
  output logic      memReq,
  output logic      done,
  output ctl_strb_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_WREQ, ST_WAIT} state_e;

  state_e stateQ, stateD;
  logic   doneQ;

  always_comb begin
    strb.latchReq   = (stateQ == ST_IDLE) && reqValid;
    strb.finishHit  = (stateQ == ST_LOOKUP) && tlbHit;
    strb.finishWalk = (stateQ == ST_WAIT) && memRespValid;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:   if (reqValid) stateD = ST_LOOKUP;
      ST_LOOKUP: stateD = tlbHit ? ST_IDLE : ST_WREQ;
      ST_WREQ:   stateD = ST_WAIT;
      ST_WAIT:   if (memRespValid) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.finishHit || strb.finishWalk;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_WREQ);
  assign done     = doneQ;

  a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  a_r7_hit_skips_walk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOOKUP && tlbHit) |=> (!memReq && doneQ));

endmodule

// File: rtl/mmu_datapath.sv
module mmu_datapath
  import mmu_pkg::*;
#(
  parameter int VA_W      = 6,
  parameter int OFF_W     = 4,
  parameter int PFN_W     = 4,
  parameter int PTE_W     = 16,
  parameter int PTE_BYTES = 2,
  parameter int MADDR_W   = 12,
  parameter int TLB_N     = 4,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PA_W     = PFN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strb_t          strb,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [1:0]         reqAcc,
  input  logic [MADDR_W-1:0] ptBase,
  input  logic               flush,
  input  logic [PTE_W-1:0]   memRdata,
  output logic               tlbHit,
  output logic [MADDR_W-1:0] memAddr,
  output fault_e             fault,
  output logic [PA_W-1:0]    pa
);
  localparam logic [VA_W-1:0] OFF_MASK = VA_W'((1 << OFF_W) - 1);
  localparam logic [VA_W-1:0] VPN_MASK = ~OFF_MASK;

  logic [VA_W-1:0]  vaQ;
  logic [1:0]       accQ;
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;

  assign vpn     = VPN_W'((vaQ & VPN_MASK) >> OFF_W);
  assign off     = OFF_W'(vaQ & OFF_MASK);
  assign memAddr = ptBase + MADDR_W'(vpn) * MADDR_W'(PTE_BYTES);

  // entry fields
  logic             pteValid, ptePresent;
  logic [2:0]       pteRwx;
  logic [PFN_W-1:0] ptePfn;
  fault_e           walkFault;

  assign pteValid   = memRdata[0];
  assign ptePresent = memRdata[1];
  assign pteRwx     = memRdata[4:2];
  assign ptePfn     = memRdata[PTE_W-1 -: PFN_W];

  always_comb begin
    if (!pteValid || !ptePresent)    walkFault = FLT_SEG;
    else if (!accessOk(accQ, pteRwx)) walkFault = FLT_PROT;
    else                              walkFault = FLT_NONE;
  end

  logic [PFN_W-1:0] hitPfn;
  logic [2:0]       hitRwx;
  logic             fillEn;

  assign fillEn = strb.finishWalk && (walkFault == FLT_NONE);

  mmu_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) uTlb (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (flush),
    .lookVpn (vpn),
    .hit     (tlbHit),
    .hitPfn  (hitPfn),
    .hitRwx  (hitRwx),
    .fillEn  (fillEn),
    .fillVpn (vpn),
    .fillPfn (ptePfn),
    .fillRwx (pteRwx)
  );

  fault_e          faultQ;
  logic [PA_W-1:0] paQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      accQ   <= '0;
      faultQ <= FLT_NONE;
      paQ    <= '0;
    end else begin
      if (strb.latchReq) begin
        vaQ  <= reqVa;
        accQ <= reqAcc;
      end
      if (strb.finishHit) begin
        if (accessOk(accQ, hitRwx)) begin
          faultQ <= FLT_NONE;
          paQ    <= {hitPfn, off};
        end else begin
          faultQ <= FLT_PROT;
          paQ    <= '0;
        end
      end else if (strb.finishWalk) begin
        faultQ <= walkFault;
        paQ    <= (walkFault == FLT_NONE) ? {ptePfn, off} : '0;
      end
    end
  end

  assign fault = faultQ;
  assign pa    = paQ;

  a_r6_invalid_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishWalk && !memRdata[0]) |=> (faultQ == FLT_SEG && paQ == '0));

endmodule

// File: rtl/mmu_translate_top.sv
module mmu_translate_top
  import mmu_pkg::*;
#(
  parameter int VA_W      = 6,
  parameter int OFF_W     = 4,
  parameter int PFN_W     = 4,
  parameter int PTE_W     = 16,
  parameter int PTE_BYTES = 2,
  parameter int MADDR_W   = 12,
  parameter int TLB_N     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [VA_W-1:0]        reqVa,
  input  logic [1:0]             reqAcc,
  input  logic [MADDR_W-1:0]     ptBase,
  input  logic                   flush,
  output logic                   memReq,
  output logic [MADDR_W-1:0]     memAddr,
  input  logic                   memRespValid,
  input  logic [PTE_W-1:0]       memRdata,
  output logic                   done,
  output logic [1:0]             fault,
  output logic [PFN_W+OFF_W-1:0] pa
);
  ctl_strb_t strb;
  logic      tlbHit;
  fault_e    faultE;

  mmu_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .tlbHit       (tlbHit),
    .memRespValid (memRespValid),
    .reqReady     (reqReady),
    .memReq       (memReq),
    .done         (done),
    .strb         (strb)
  );

  mmu_datapath #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .PTE_W(PTE_W),
    .PTE_BYTES(PTE_BYTES), .MADDR_W(MADDR_W), .TLB_N(TLB_N)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqVa    (reqVa),
    .reqAcc   (reqAcc),
    .ptBase   (ptBase),
    .flush    (flush),
    .memRdata (memRdata),
    .tlbHit   (tlbHit),
    .memAddr  (memAddr),
    .fault    (faultE),
    .pa       (pa)
  );

  assign fault = faultE;

endmodule

// File: tb/tb_mmu_translate_top.sv
module tb_mmu_translate_top;
  localparam int VA_W = 8, OFF_W = 4, PFN_W = 4, PTE_W = 16, PTE_BYTES = 2, MADDR_W = 12;
  localparam logic [MADDR_W-1:0] BASE = 12'h100;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [VA_W-1:0] reqVa = '0;
  logic [1:0] reqAcc = '0;
  logic flushMan = 1'b0, flushAuto = 1'b0, flushOnResp = 1'b0;
  logic memReq, memRespValid = 1'b0, done;
  logic [MADDR_W-1:0] memAddr, lastAddr = '0;
  logic [PTE_W-1:0] memRdata = '0;
  logic [1:0] fault;
  logic [7:0] pa;

  int checks = 0, errors = 0, reqCount = 0, memDelay = 0, rspCnt = 0, rspIdx = 0;
  logic rspPend = 1'b0;
  logic [PTE_W-1:0] ptMem [16];

  always #5 clk = ~clk;

  mmu_translate_top #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .PTE_W(PTE_W),
    .PTE_BYTES(PTE_BYTES), .MADDR_W(MADDR_W), .TLB_N(4)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
    .reqAcc(reqAcc), .ptBase(BASE), .flush(flushMan | flushAuto), .memReq(memReq),
    .memAddr(memAddr), .memRespValid(memRespValid), .memRdata(memRdata), .done(done),
    .fault(fault), .pa(pa));

  // memory model: response comes memDelay cycles after the request cycle
  always @(negedge clk) begin
    if (rspPend && rspCnt == 0) begin
      memRespValid <= 1'b1;
      memRdata     <= ptMem[rspIdx];
      flushAuto    <= flushOnResp;
      rspPend      <= 1'b0;
    end else begin
      memRespValid <= 1'b0;
      flushAuto    <= 1'b0;
      if (rspPend) rspCnt <= rspCnt - 1;
    end
    if (memReq) begin
      rspPend  <= 1'b1;
      rspCnt   <= memDelay;
      reqCount <= reqCount + 1;
      lastAddr <= memAddr;
      rspIdx   <= int'((memAddr - BASE) >> 1) & 15;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [7:0] va, input logic [1:0] acc, input int d,
                       input int expF, input int expPa, input bit expMem, input string req);
    int c0, lat;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqAcc = acc; memDelay = d; c0 = reqCount;
    @(negedge clk);
    reqValid = 1'b0; lat = 1;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    chk({req, " fault"}, int'(fault), expF);
    chk({req, " pa"}, int'(pa), expPa);
    chk({req, " mem reads"}, reqCount - c0, expMem ? 1 : 0);
    chk({req, " latency"}, lat, expMem ? 4 + d : 2);
    if (expMem) chk({req, " R2 pte addr"}, int'(lastAddr), int'(BASE) + int'(va[7:4]) * PTE_BYTES);
    @(negedge clk);
    chk("R12 done one cycle", int'(done), 0);
  endtask

  // {va[8], acc[2], delay[4], fault[2], pa[8], mem[1]}
  localparam logic [24:0] VEC [18] = '{
    {8'h15, 2'd0, 4'd0, 2'd0, 8'hA5, 1'b1},  // R1 R3 addr 21
    {8'h1C, 2'd0, 4'd0, 2'd0, 8'hAC, 1'b0},  // R7 R8 hit
    {8'h1C, 2'd1, 4'd0, 2'd2, 8'h00, 1'b0},  // R9 write to read-only hit
    {8'h23, 2'd1, 4'd3, 2'd0, 8'h33, 1'b1},  // R8 wait cycles
    {8'h2F, 2'd2, 4'd0, 2'd0, 8'h3F, 1'b0},  // R7 exec hit
    {8'h30, 2'd0, 4'd1, 2'd1, 8'h00, 1'b1},  // R6 invalid, no perms
    {8'h30, 2'd0, 4'd0, 2'd1, 8'h00, 1'b1},  // R4 not cached
    {8'h41, 2'd1, 4'd2, 2'd1, 8'h00, 1'b1},  // R4 not present
    {8'h57, 2'd0, 4'd0, 2'd2, 8'h00, 1'b1},  // R5 read exec-only
    {8'h57, 2'd0, 4'd0, 2'd2, 8'h00, 1'b1},  // R5 not cached
    {8'h5A, 2'd2, 4'd0, 2'd0, 8'h6A, 1'b1},  // R5 exec ok
    {8'h5B, 2'd3, 4'd0, 2'd0, 8'h6B, 1'b0},  // R5 code 3 is exec, hit
    {8'h60, 2'd1, 4'd0, 2'd0, 8'h60, 1'b1},  // R10 fourth slot
    {8'h15, 2'd0, 4'd0, 2'd0, 8'hA5, 1'b0},  // R10 still cached
    {8'h71, 2'd0, 4'd0, 2'd0, 8'h71, 1'b1},  // R10 evicts page 1
    {8'h22, 2'd0, 4'd0, 2'd0, 8'h32, 1'b0},  // R10 page 2 kept
    {8'h15, 2'd0, 4'd0, 2'd0, 8'hA5, 1'b1},  // R10 page 1 refetched
    {8'h24, 2'd0, 4'd0, 2'd0, 8'h34, 1'b1}   // R10 page 2 evicted
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ptMem[i] = 16'h0000;
    ptMem[1] = 16'hA007; ptMem[2] = 16'h301F; ptMem[3] = 16'h0002;
    ptMem[4] = 16'h501D; ptMem[5] = 16'h6013; ptMem[6] = 16'h600F;
    ptMem[7] = 16'h700F; ptMem[8] = 16'h800F; ptMem[9] = 16'h900F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 done", int'(done), 0);
    chk("R13 ready", int'(reqReady), 1);
    chk("R13 memReq", int'(memReq), 0);
    chk("R13 fault", int'(fault), 0);
    chk("R13 pa", int'(pa), 0);

    for (int i = 0; i < 18; i++) begin
      logic [24:0] v;
      v = VEC[i];
      xlate(v[24:17], v[16:15], int'(v[14:11]), int'(v[10:9]), int'(v[8:1]), v[0],
            $sformatf("vec%0d", i));
    end

    // R11: stale translation until flush
    ptMem[1] = 16'hB007;
    xlate(8'h15, 2'd0, 0, 0, 8'hA5, 1'b0, "R11 stale before flush");
    @(negedge clk); flushMan = 1'b1;
    @(negedge clk); flushMan = 1'b0;
    xlate(8'h15, 2'd0, 0, 0, 8'hB5, 1'b1, "R11 after flush");

    // R11: flush in the fill cycle wins
    flushOnResp = 1'b1;
    xlate(8'h84, 2'd0, 2, 0, 8'h84, 1'b1, "R11 flush with fill");
    flushOnResp = 1'b0;
    xlate(8'h84, 2'd0, 0, 0, 8'h84, 1'b1, "R11 fill dropped");

    // R12: requests while busy are ignored
    begin
      int c0;
      @(negedge clk);
      reqValid = 1'b1; reqVa = 8'h92; reqAcc = 2'd1; memDelay = 5; c0 = reqCount;
      @(negedge clk);
      reqVa = 8'h15; reqAcc = 2'd0;
      @(negedge clk);
      chk("R12 ready low while busy", int'(reqReady), 0);
      @(negedge clk); @(negedge clk);
      reqValid = 1'b0;
      while (!done) @(negedge clk);
      chk("R12 busy result pa", int'(pa), 8'h92);
      chk("R12 busy result fault", int'(fault), 0);
      repeat (4) begin
        @(negedge clk);
        chk("R12 no extra done", int'(done), 0);
      end
      chk("R12 single walk", reqCount - c0, 1);
      chk("R12 ready again", int'(reqReady), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule